// File: doc/BRIEF.md
# EPP Cycle Engine

This block turns host register accesses at the enhanced parallel port offsets into byte-wide handshaked transfers on a parallel peripheral bus. An access at offset 3 runs an address cycle. An access at offset 4 runs a data cycle of one, two or four bytes, sent least significant byte first. Each byte lowers an active-low address or data strobe. On writes it also lowers the write line and drives the data lines. The strobe then stays low until the peripheral raises its wait line.

A cycle runs only when the control register, which lives in a neighbouring block, holds the exact pattern for the requested direction. Any other pattern drops the access without touching the bus. If the peripheral does not answer within a programmable number of clocks, the block aborts the access, skips any remaining bytes, and sets a sticky timeout flag. The host sees this flag in status bit 0 and clears it by writing status with bit 0 set. A second 8-byte window reads 0xFF and ignores writes.

The host issues one request pulse and waits for the done pulse before it issues the next request. Read data is valid in the cycle of done.

Top module: `epp_cycle_engine`

## Requirements
- R1: A write at offset 3 or 4 runs a bus cycle only if `(ctrl_reg & 8'h2F) == 8'h04`. Otherwise no strobe or write line moves, and done comes one cycle after the request with read data 0.
- R2: A read at offset 3 or 4 runs a bus cycle only if `(ctrl_reg & 8'h2F) == 8'h24`. Otherwise no strobe moves, and done comes one cycle after the request with all ones at the access width (0xFF, 0xFFFF or 0xFFFFFFFF) and zero above it.
- R3: Offset 3 moves exactly one byte using `bus_astb_n`. Offset 4 uses `bus_dstb_n`. The two strobes are never low together.
- R4: `host_size` 0 moves 1 byte, 1 moves 2 bytes, 2 or 3 moves 4 bytes. Byte i is data bits [8i+7:8i], and byte 0 goes first. Offset 3 ignores `host_size`.
- R5: During a byte, the strobe is low and stays low until `bus_wait` is sampled high. On writes, `bus_write_n` is low and `bus_data_oe` is high for the whole byte and the release cycle after it. Every byte is followed by one cycle with both strobes high.
- R6: If `bus_wait` is not sampled high within `tmo_limit` strobe cycles (0 counts as 1), the access ends. The timeout flag sets and the remaining bytes are skipped. Read bytes that were not transferred return 0xFF.
- R7: A read at offset 1 returns `{per_status_hi, timeout_flag}` in bits 7:0.
- R8: A write at offset 1 with data bit 0 set clears the timeout flag. With bit 0 clear, the write leaves the flag unchanged. The flag otherwise holds until reset.
- R9: Reset clears the timeout flag, ends any access, and holds both strobes, `bus_write_n` and `host_done` inactive.
- R10: Requests with `host_hi_win` set complete one cycle later with read data 0xFF. They move no bus line and do not change the timeout flag.
- R11: `host_done` is a single-cycle pulse that carries valid `host_rdata`. Reads at offsets other than 1, 3 and 4 return 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_req | input | 1 | One-cycle access request, accepted when idle |
| host_we | input | 1 | 1 = write, 0 = read |
| host_hi_win | input | 1 | Access targets the second 8-byte window |
| host_ofs | input | 3 | Register offset within the window |
| host_size | input | 2 | Access width code (R4) |
| host_wdata | input | 32 | Write data |
| host_done | output | 1 | Access complete pulse |
| host_rdata | output | 32 | Read data, valid with done |
| ctrl_reg | input | 8 | Current control register value |
| per_status_hi | input | 7 | Peripheral status lines for status bits 7:1 |
| tmo_limit | input | 16 | Handshake timeout in clock cycles |
| bus_data_out | output | 8 | Byte driven to the peripheral |
| bus_data_oe | output | 1 | Data line output enable |
| bus_data_in | input | 8 | Byte from the peripheral |
| bus_astb_n | output | 1 | Address strobe, active low |
| bus_dstb_n | output | 1 | Data strobe, active low |
| bus_write_n | output | 1 | Write direction, active low |
| bus_wait | input | 1 | Peripheral handshake, high = ready |

## Verification
The assertions check the following on every cycle:
- the two strobes are never low together;
- the strobe-low run never exceeds the timeout limit;
- done is a single-cycle pulse;
- a mismatched control pattern or a second-window access leaves the bus quiet and finishes the next cycle;
- the timeout flag holds until a qualifying status write, and that write clears it;
- a status read returns the flag and the peripheral lines.

Only the bench scenarios can show the following:
- the order and content of the transferred bytes;
- the per-byte cycle timing against varying peripheral delays;
- the assembly of partial read data after a timeout in the middle of an access;
- the treatment of a zero limit;
- the flag clear on reset.

// File: rtl/epp_pkg.sv
package epp_pkg;
  localparam int BYTE_W = 8;
  typedef logic [2:0] ofs_t;
  localparam ofs_t OFS_STATUS   = 3'd1;
  localparam ofs_t OFS_EPP_ADDR = 3'd3;
  localparam ofs_t OFS_EPP_DATA = 3'd4;
  localparam logic [7:0] GATE_MASK = 8'h2F;
  localparam logic [7:0] GATE_WR   = 8'h04;
  localparam logic [7:0] GATE_RD   = 8'h24;
  localparam logic [7:0] IDLE_BYTE = 8'hFF;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_STB  = 2'd1,
    ST_REL  = 2'd2,
    ST_DONE = 2'd3
  } eng_state_t;
endpackage

// File: rtl/epp_rst_sync.sv
module epp_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic s1_q, s2_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= 1'b1;
      s2_q <= s1_q;
    end
  end
  assign rst_sync_n = s2_q;
endmodule

// File: rtl/epp_access_decode.sv
module epp_access_decode
  import epp_pkg::*;
#(
  parameter int NB = 4,
  localparam int DW = NB * BYTE_W,
  localparam int IDX_W = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic             accept,
  input  logic             we,
  input  logic             hi_win,
  input  ofs_t             ofs,
  input  logic [1:0]       size,
  input  logic             wdata_b0,
  input  logic [7:0]       ctrl,
  input  logic [6:0]       per_status_hi,
  input  logic             tmo_flag,
  output logic             run_bus,
  output logic             is_addr,
  output logic [IDX_W-1:0] last_idx,
  output logic [DW-1:0]    init_rdata,
  output logic             clr_tmo
);
  logic       epp_ofs;
  logic       pat_ok;
  logic [7:0] masked;
  int         last_i;
  logic [DW-1:0] width_ones;

  assign masked  = ctrl & GATE_MASK;
  assign pat_ok  = we ? (masked == GATE_WR) : (masked == GATE_RD);
  assign is_addr = (ofs == OFS_EPP_ADDR);
  assign epp_ofs = !hi_win && (is_addr || (ofs == OFS_EPP_DATA));
  assign run_bus = accept && epp_ofs && pat_ok;
  assign clr_tmo = accept && we && !hi_win && (ofs == OFS_STATUS) && wdata_b0;

  always_comb begin
    if (is_addr || size == 2'd0) last_i = 0;
    else if (size == 2'd1)       last_i = 1;
    else                         last_i = 3;
    if (last_i > NB - 1) last_i = NB - 1;
    last_idx = IDX_W'(last_i);
    for (int b = 0; b < NB; b++)
      width_ones[b*BYTE_W +: BYTE_W] = (b <= last_i) ? IDLE_BYTE : '0;
  end

  always_comb begin
    init_rdata = '0;
    if (we)                       init_rdata = '0;
    else if (hi_win)              init_rdata[BYTE_W-1:0] = IDLE_BYTE;
    else if (ofs == OFS_STATUS)   init_rdata[BYTE_W-1:0] = {per_status_hi, tmo_flag};
    else if (epp_ofs)             init_rdata = width_ones;
    else                          init_rdata[BYTE_W-1:0] = IDLE_BYTE;
  end
endmodule

// File: rtl/epp_sticky_flag.sv
module epp_sticky_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic q
);
  logic q_n, q_r;
  always_comb begin
    q_n = q_r;
    if (set)      q_n = 1'b1;
    else if (clr) q_n = 1'b0;
  end
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_r <= 1'b0;
    else        q_r <= q_n;
  end
  assign q = q_r;
endmodule

// File: rtl/epp_byte_engine.sv
module epp_byte_engine
  import epp_pkg::*;
#(
  parameter int NB = 4,
  parameter int TMO_W = 16,
  localparam int DW = NB * BYTE_W,
  localparam int IDX_W = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             run_bus,
  input  logic             is_wr,
  input  logic             is_addr,
  input  logic [IDX_W-1:0] last_idx,
  input  logic [DW-1:0]    init_rdata,
  input  logic [DW-1:0]    wdata,
  input  logic [TMO_W-1:0] tmo_limit,
  input  logic             bus_wait,
  input  logic [7:0]       bus_data_in,
  output logic             idle,
  output logic             done,
  output logic [DW-1:0]    rdata,
  output logic             tmo_evt,
  output logic             astb_n,
  output logic             dstb_n,
  output logic             write_n,
  output logic             data_oe,
  output logic [7:0]       data_out
);
  eng_state_t       st_q, st_n;
  logic [IDX_W-1:0] idx_q, idx_n, last_q;
  logic [TMO_W-1:0] cnt_q, cnt_n;
  logic [TMO_W:0]   cnt_inc;
  logic [DW-1:0]    rd_q, rd_n, wd_q;
  logic             wr_q, addr_q, load, on_bus;

  assign load    = (st_q == ST_IDLE) && start;
  assign cnt_inc = {1'b0, cnt_q} + {{TMO_W{1'b0}}, 1'b1};

  always_comb begin
    st_n    = st_q;
    idx_n   = idx_q;
    cnt_n   = cnt_q;
    rd_n    = rd_q;
    tmo_evt = 1'b0;
    case (st_q)
      ST_IDLE: if (start) begin
        rd_n  = init_rdata;
        idx_n = '0;
        cnt_n = '0;
        st_n  = run_bus ? ST_STB : ST_DONE;
      end
      ST_STB: begin
        if (bus_wait) begin
          if (!wr_q) rd_n[idx_q*BYTE_W +: BYTE_W] = bus_data_in;
          st_n = ST_REL;
        end else if (cnt_inc >= {1'b0, tmo_limit}) begin
          tmo_evt = 1'b1;
          st_n    = ST_DONE;
        end else begin
          cnt_n = cnt_inc[TMO_W-1:0];
        end
      end
      ST_REL: begin
        if (idx_q == last_q) begin
          st_n = ST_DONE;
        end else begin
          idx_n = idx_q + IDX_W'(1);
          cnt_n = '0;
          st_n  = ST_STB;
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      idx_q <= '0;
      cnt_q <= '0;
      rd_q  <= '0;
    end else begin
      st_q  <= st_n;
      idx_q <= idx_n;
      cnt_q <= cnt_n;
      rd_q  <= rd_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q   <= 1'b0;
      addr_q <= 1'b0;
      last_q <= '0;
      wd_q   <= '0;
    end else if (load) begin
      wr_q   <= is_wr;
      addr_q <= is_addr;
      last_q <= last_idx;
      wd_q   <= wdata;
    end
  end

  assign on_bus   = (st_q == ST_STB) || (st_q == ST_REL);
  assign idle     = (st_q == ST_IDLE);
  assign done     = (st_q == ST_DONE);
  assign rdata    = rd_q;
  assign astb_n   = !((st_q == ST_STB) && addr_q);
  assign dstb_n   = !((st_q == ST_STB) && !addr_q);
  assign write_n  = !(on_bus && wr_q);
  assign data_oe  = on_bus && wr_q;
  assign data_out = wd_q[idx_q*BYTE_W +: BYTE_W];
endmodule

// File: rtl/epp_cycle_engine.sv
module epp_cycle_engine
  import epp_pkg::*;
#(
  parameter int NB = 4,
  parameter int TMO_W = 16,
  localparam int DW = NB * BYTE_W,
  localparam int IDX_W = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_req,
  input  logic             host_we,
  input  logic             host_hi_win,
  input  logic [2:0]       host_ofs,
  input  logic [1:0]       host_size,
  input  logic [DW-1:0]    host_wdata,
  output logic             host_done,
  output logic [DW-1:0]    host_rdata,
  input  logic [7:0]       ctrl_reg,
  input  logic [6:0]       per_status_hi,
  input  logic [TMO_W-1:0] tmo_limit,
  output logic [7:0]       bus_data_out,
  output logic             bus_data_oe,
  input  logic [7:0]       bus_data_in,
  output logic             bus_astb_n,
  output logic             bus_dstb_n,
  output logic             bus_write_n,
  input  logic             bus_wait
);
  logic             rst_sync_n;
  logic             eng_idle, accept, tmo_flag, tmo_evt, clr_tmo;
  logic             run_bus, is_addr;
  logic [IDX_W-1:0] last_idx;
  logic [DW-1:0]    init_rdata;

  assign accept = host_req && eng_idle;

  epp_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n));

  epp_access_decode #(.NB(NB)) u_dec (
    .accept(accept), .we(host_we), .hi_win(host_hi_win), .ofs(host_ofs),
    .size(host_size), .wdata_b0(host_wdata[0]), .ctrl(ctrl_reg),
    .per_status_hi(per_status_hi), .tmo_flag(tmo_flag), .run_bus(run_bus),
    .is_addr(is_addr), .last_idx(last_idx), .init_rdata(init_rdata),
    .clr_tmo(clr_tmo)
  );

  epp_byte_engine #(.NB(NB), .TMO_W(TMO_W)) u_eng (
    .clk(clk), .rst_n(rst_sync_n), .start(accept), .run_bus(run_bus),
    .is_wr(host_we), .is_addr(is_addr), .last_idx(last_idx),
    .init_rdata(init_rdata), .wdata(host_wdata), .tmo_limit(tmo_limit),
    .bus_wait(bus_wait), .bus_data_in(bus_data_in), .idle(eng_idle),
    .done(host_done), .rdata(host_rdata), .tmo_evt(tmo_evt),
    .astb_n(bus_astb_n), .dstb_n(bus_dstb_n), .write_n(bus_write_n),
    .data_oe(bus_data_oe), .data_out(bus_data_out)
  );

  epp_sticky_flag u_tmo (
    .clk(clk), .rst_n(rst_sync_n), .set(tmo_evt), .clr(clr_tmo), .q(tmo_flag)
  );
endmodule

// File: rtl/epp_cycle_engine_chk.sv
module epp_cycle_engine_chk
  import epp_pkg::*;
#(
  parameter int NB = 4,
  parameter int TMO_W = 16,
  localparam int DW = NB * BYTE_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic             host_req,
  input logic             host_we,
  input logic             host_hi_win,
  input logic [2:0]       host_ofs,
  input logic             host_wdata0,
  input logic             host_done,
  input logic [DW-1:0]    host_rdata,
  input logic [7:0]       ctrl_reg,
  input logic [6:0]       per_status_hi,
  input logic [TMO_W-1:0] tmo_limit,
  input logic             astb_n,
  input logic             dstb_n,
  input logic             eng_idle,
  input logic             tmo_flag
);
  logic           acc, epp_ofs, quiet, clr_req;
  logic [TMO_W:0] low_run, eff_lim;

  assign acc     = host_req && eng_idle;
  assign epp_ofs = !host_hi_win && (host_ofs == OFS_EPP_ADDR || host_ofs == OFS_EPP_DATA);
  assign quiet   = astb_n && dstb_n;
  assign clr_req = acc && host_we && !host_hi_win && host_ofs == OFS_STATUS && host_wdata0;
  assign eff_lim = (tmo_limit == '0) ? {{TMO_W{1'b0}}, 1'b1} : {1'b0, tmo_limit};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     low_run <= '0;
    else if (quiet) low_run <= '0;
    else            low_run <= low_run + 1'b1;
  end

  p_one_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n) !(!astb_n && !dstb_n));
  p_drop_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && host_we && epp_ofs && ((ctrl_reg & GATE_MASK) != GATE_WR))
    |=> (quiet && host_done && host_rdata == '0));
  p_drop_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !host_we && epp_ofs && ((ctrl_reg & GATE_MASK) != GATE_RD))
    |=> (quiet && host_done && host_rdata[7:0] == 8'hFF));
  p_strobe_bound_r6: assert property (@(posedge clk) disable iff (!rst_n) low_run <= eff_lim);
  p_status_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !host_we && !host_hi_win && host_ofs == OFS_STATUS)
    |=> (host_rdata[7:0] == {$past(per_status_hi), $past(tmo_flag)}));
  p_flag_clear_r8: assert property (@(posedge clk) disable iff (!rst_n) clr_req |=> !tmo_flag);
  p_flag_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo_flag && !clr_req) |=> tmo_flag);
  p_hi_window_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && host_hi_win) |=> (quiet && host_done && (host_we || host_rdata[7:0] == 8'hFF)));
  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n) host_done |=> !host_done);
endmodule

bind epp_cycle_engine epp_cycle_engine_chk #(.NB(NB), .TMO_W(TMO_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_we(host_we),
  .host_hi_win(host_hi_win), .host_ofs(host_ofs), .host_wdata0(host_wdata[0]),
  .host_done(host_done), .host_rdata(host_rdata), .ctrl_reg(ctrl_reg),
  .per_status_hi(per_status_hi), .tmo_limit(tmo_limit), .astb_n(bus_astb_n),
  .dstb_n(bus_dstb_n), .eng_idle(eng_idle), .tmo_flag(tmo_flag)
);

// File: tb/epp_cycle_engine_tb_top.sv
`timescale 1ns/1ps
module epp_cycle_engine_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_req = 1'b0, host_we = 1'b0, host_hi_win = 1'b0;
  logic [2:0]  host_ofs = '0;
  logic [1:0]  host_size = '0;
  logic [31:0] host_wdata = '0;
  logic        host_done;
  logic [31:0] host_rdata;
  logic [7:0]  ctrl_reg = 8'h00;
  logic [6:0]  per_status_hi = 7'h00;
  logic [15:0] tmo_limit = 16'd8;
  logic [7:0]  bus_data_out, bus_data_in = 8'h00;
  logic        bus_data_oe, bus_astb_n, bus_dstb_n, bus_write_n;
  logic        bus_wait = 1'b0;

  int n_cmp = 0, n_bad = 0, cyc = 0;
  int dly[4] = '{2, 2, 2, 2};
  logic [7:0] rd_src[4] = '{8'h11, 8'h22, 8'h33, 8'h44};
  int low_cnt = 0, byte_ptr = 0;
  logic [7:0] wr_seen[$];
  bit m_tmo = 1'b0;

  always #2.5 clk = ~clk;

  epp_cycle_engine dut_i (
    .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_we(host_we),
    .host_hi_win(host_hi_win), .host_ofs(host_ofs), .host_size(host_size),
    .host_wdata(host_wdata), .host_done(host_done), .host_rdata(host_rdata),
    .ctrl_reg(ctrl_reg), .per_status_hi(per_status_hi), .tmo_limit(tmo_limit),
    .bus_data_out(bus_data_out), .bus_data_oe(bus_data_oe), .bus_data_in(bus_data_in),
    .bus_astb_n(bus_astb_n), .bus_dstb_n(bus_dstb_n), .bus_write_n(bus_write_n),
    .bus_wait(bus_wait)
  );

  // Peripheral: raises wait once the strobe has been low for dly[byte] samples.
  always @(negedge clk) begin
    if (!bus_astb_n || !bus_dstb_n) begin
      low_cnt = low_cnt + 1;
      if (low_cnt == dly[byte_ptr] && !bus_write_n) wr_seen.push_back(bus_data_out);
      bus_wait = (low_cnt >= dly[byte_ptr]);
    end else begin
      if (low_cnt != 0 && byte_ptr < 3) byte_ptr = byte_ptr + 1;
      low_cnt = 0;
      bus_wait = 1'b0;
    end
    bus_data_in = rd_src[byte_ptr];
  end

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (cyc > 100000) begin
      n_cmp = n_cmp + 1; n_bad = n_bad + 1;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      summary();
    end
  end

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_cmp = n_cmp + 1;
    if (!ok) begin
      n_bad = n_bad + 1;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  function automatic logic [4:0] pins();
    return {bus_astb_n, bus_dstb_n, bus_write_n, bus_data_oe, host_done};
  endfunction

  task automatic access(input bit we, input logic [2:0] ofs, input bit hi,
                        input logic [1:0] sz, input logic [31:0] wd, input string rq);
    int nb, xfer, lim;
    bit is_a, bus, tmo_hit;
    logic [31:0] ones, exp_rd;
    logic [4:0] expv;
    is_a = (ofs == 3'd3);
    nb = is_a ? 1 : (sz == 2'd0 ? 1 : (sz == 2'd1 ? 2 : 4));
    ones = (nb == 1) ? 32'hFF : (nb == 2) ? 32'hFFFF : 32'hFFFF_FFFF;
    bus = !hi && (ofs == 3'd3 || ofs == 3'd4) &&
          ((ctrl_reg & 8'h2F) == (we ? 8'h04 : 8'h24));
    lim = (tmo_limit == 0) ? 1 : int'(tmo_limit);
    xfer = 0; tmo_hit = 0;
    @(negedge clk);
    byte_ptr = 0; wr_seen.delete();
    host_req = 1'b1; host_we = we; host_ofs = ofs; host_hi_win = hi;
    host_size = sz; host_wdata = wd;
    @(negedge clk);
    host_req = 1'b0;
    if (bus) begin
      for (int b = 0; b < nb && !tmo_hit; b++) begin
        for (int k = 1; k < 100000; k++) begin
          expv = {is_a ? 1'b0 : 1'b1, is_a ? 1'b1 : 1'b0, !we, we, 1'b0};
          chk(pins() == expv, {rq, " strobe R5"}, 32'(pins()), 32'(expv));
          if (k >= dly[b]) begin
            xfer++;
            @(negedge clk);
            expv = {2'b11, !we, we, 1'b0};
            chk(pins() == expv, "R5 release", 32'(pins()), 32'(expv));
            @(negedge clk);
            break;
          end
          if (k >= lim) begin
            tmo_hit = 1;
            @(negedge clk);
            break;
          end
          @(negedge clk);
        end
      end
    end
    if (we)                           exp_rd = 32'h0;
    else if (hi)                      exp_rd = 32'hFF;
    else if (ofs == 3'd1)             exp_rd = {24'h0, per_status_hi, m_tmo};
    else if (ofs == 3'd3 || ofs == 3'd4) begin
      exp_rd = ones;
      if (bus) for (int b = 0; b < xfer; b++) exp_rd[8*b +: 8] = rd_src[b];
    end else                          exp_rd = 32'hFF;
    chk(pins() == 5'b11101, {rq, " done R11"}, 32'(pins()), 32'h1D);
    chk(host_rdata == exp_rd, {rq, " rdata"}, host_rdata, exp_rd);
    if (we && bus) begin
      chk(wr_seen.size() == xfer, {rq, " byte count R4"}, wr_seen.size(), xfer);
      for (int b = 0; b < xfer && b < wr_seen.size(); b++)
        chk(wr_seen[b] == wd[8*b +: 8], {rq, " byte order R4"}, wr_seen[b], wd[8*b +: 8]);
    end
    if (tmo_hit) m_tmo = 1'b1;
    if (we && !hi && ofs == 3'd1 && wd[0]) m_tmo = 1'b0;
    @(negedge clk);
    chk(pins() == 5'b11100, {rq, " done pulse R11"}, 32'(pins()), 32'h1C);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(pins() == 5'b11100, "R9 during reset", 32'(pins()), 32'h1C);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    m_tmo = 1'b0;
    chk(pins() == 5'b11100, "R9 after reset", 32'(pins()), 32'h1C);
  endtask

  initial begin
    do_reset();
    access(0, 3'd1, 0, 0, 0, "R9 status flag clear");
    per_status_hi = 7'h55;
    access(0, 3'd1, 0, 0, 0, "R7 status lines");
    // Writes
    ctrl_reg = 8'h04; tmo_limit = 16'd8;
    dly = '{2, 2, 2, 2};
    access(1, 3'd3, 0, 2'd2, 32'h0000_005A, "R3 addr write");
    dly = '{1, 3, 2, 4};
    access(1, 3'd4, 0, 2'd2, 32'hA1B2_C3D4, "R4 word write");
    access(1, 3'd4, 0, 2'd1, 32'h1234_BEEF, "R4 half write");
    access(1, 3'd4, 0, 2'd3, 32'h5566_7788, "R4 size3 write");
    ctrl_reg = 8'hD4;
    access(1, 3'd4, 0, 2'd0, 32'h0000_00C3, "R1 extra bits ok");
    // Reads
    ctrl_reg = 8'h24; dly = '{2, 1, 3, 2};
    access(0, 3'd4, 0, 2'd2, 0, "R4 word read");
    access(0, 3'd4, 0, 2'd1, 0, "R4 half read");
    access(0, 3'd3, 0, 2'd2, 0, "R3 addr read");
    // Gating
    access(1, 3'd4, 0, 2'd2, 32'hDEAD_BEEF, "R1 wrong pattern write");
    ctrl_reg = 8'h2C;
    access(1, 3'd3, 0, 2'd0, 32'h0000_0011, "R1 select bit set write");
    ctrl_reg = 8'h04;
    access(0, 3'd4, 0, 2'd0, 0, "R2 byte read dropped");
    access(0, 3'd4, 0, 2'd1, 0, "R2 half read dropped");
    access(0, 3'd4, 0, 2'd2, 0, "R2 word read dropped");
    ctrl_reg = 8'h25;
    access(0, 3'd3, 0, 2'd0, 0, "R2 strobe bit set read");
    // Timeout in the middle of a read
    ctrl_reg = 8'h24; tmo_limit = 16'd4; dly = '{1, 2, 9, 1};
    access(0, 3'd4, 0, 2'd2, 0, "R6 read timeout");
    access(0, 3'd1, 0, 0, 0, "R7 flag visible");
    access(1, 3'd1, 0, 0, 32'h0000_00FE, "R8 bit0 clear no effect");
    access(0, 3'd1, 0, 0, 0, "R8 flag held");
    access(1, 3'd1, 1, 0, 32'h0000_0001, "R10 high window write");
    access(0, 3'd1, 0, 0, 0, "R10 flag untouched");
    access(0, 3'd2, 1, 0, 0, "R10 high window read");
    access(1, 3'd1, 0, 0, 32'h0000_0001, "R8 clear");
    access(0, 3'd1, 0, 0, 0, "R8 flag cleared");
    access(0, 3'd0, 0, 0, 0, "R11 other offset read");
    // Timeout in the middle of a write
    ctrl_reg = 8'h04; dly = '{1, 9, 1, 1};
    access(1, 3'd4, 0, 2'd2, 32'hCAFE_F00D, "R6 write timeout");
    access(0, 3'd1, 0, 0, 0, "R6 flag set");
    access(1, 3'd1, 0, 0, 32'h0000_0001, "R8 clear again");
    // Zero limit behaves as one
    tmo_limit = 16'd0; dly = '{1, 1, 1, 1};
    access(1, 3'd3, 0, 0, 32'h0000_0077, "R6 zero limit pass");
    access(0, 3'd1, 0, 0, 0, "R6 zero limit no flag");
    dly = '{2, 2, 2, 2};
    access(1, 3'd3, 0, 0, 32'h0000_0078, "R6 zero limit timeout");
    access(0, 3'd1, 0, 0, 0, "R6 zero limit flag");
    // Reset clears the flag
    do_reset();
    access(0, 3'd1, 0, 0, 0, "R9 flag after reset");
    summary();
  end
endmodule